// File: doc/BRIEF.md
# Mixed I3C/I2C Bus Bit Modulator

This block turns single bus commands into open-drain pin activity on a shared two-wire bus that carries both I3C targets and legacy I2C targets. A transfer sequencer hands it one command at a time: open a transfer (Start or repeated Start), close it (Stop), write a bit, read a bit, or return an acknowledge. The block then steps that command through four equal quarter-phases and drives the SCL and SDA pull-down enables for each one. While a read bit runs, it samples the resolved SDA line and returns the value with a one-cycle strobe.

Each command carries a mode flag. In I3C mode a quarter-phase lasts `QTR_TICKS` clocks, which gives an open-drain rate near 1.5 MHz at the intended system clock. In legacy mode a quarter lasts `QTR_TICKS * LEGACY_DIV` clocks. Legacy targets running at 100 kHz or 400 kHz therefore see pulses long enough to pass their spike filters.

The block tracks whether the bus is currently held, meaning a Stop has not yet been issued. An open command on a held bus becomes a repeated Start. An open command on a free bus becomes a plain Start. This rule holds whichever of the two open codes was sent. As a result, a Stop followed by a separately queued transfer never inserts a stray SCL pulse.

Top module: `mixbus_bitmod`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are both 0 (lines released), `cmd_ready` is 1, `busy` and `rd_valid` are 0, and the bus counts as free, so the first open command yields a plain Start.
- R2: An I3C-mode command (`cmd_legacy`=0) keeps `busy` high for exactly 4*`QTR_TICKS` cycles, starting in the cycle after acceptance.
- R3: A legacy-mode command (`cmd_legacy`=1) keeps `busy` high for exactly 4*`QTR_TICKS`*`LEGACY_DIV` cycles.
- R4: A write bit (`cmd_op`=3) drives SDA low for the whole bit when `cmd_bit`=0 and releases it when `cmd_bit`=1. SCL is pulled low in quarters 0 and 3 and released in quarters 1 and 2.
- R5: A plain Start keeps SCL released through quarters 0 to 2 and pulls SDA low from quarter 2 onward. SCL is then pulled low in quarter 3, so SDA falls while SCL is high.
- R6: On a held bus, an open command (`cmd_op`=0 or 1) produces a repeated Start. Quarter 0 has SCL low and SDA released. Quarter 1 releases SCL. Quarter 2 pulls SDA low. Quarter 3 pulls SCL low.
- R7: A Stop (`cmd_op`=2) holds SCL and SDA low in quarter 0, releases SCL in quarter 1, and releases SDA in quarters 2 and 3. It leaves the bus free.
- R8: After a Stop, an open command, including the repeated-Start code 1, produces a plain Start, so no SCL low pulse occurs between the Stop and the Start.
- R9: A read bit (`cmd_op`=4) keeps SDA released and uses the R4 SCL pattern. In the cycle after `busy` falls, it raises `rd_valid` for one cycle with `rd_data` equal to the line level sampled at the end of quarter 1.
- R10: An acknowledge bit (`cmd_op`=5) drives SDA low for the whole bit when `cmd_bit`=0 (ACK) and releases it when `cmd_bit`=1 (NACK). It uses the R4 SCL pattern.
- R11: A command is accepted only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while `busy` is high. A `cmd_valid` raised during a running command changes neither the pins nor that command's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Modulator can take a command |
| cmd_op | input | 3 | Command code: 0 Start, 1 repeated Start, 2 Stop, 3 write, 4 read, 5 acknowledge |
| cmd_bit | input | 1 | Data value for a write; 0 = ACK, 1 = NACK for an acknowledge |
| cmd_legacy | input | 1 | 1 selects the divided legacy timing |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A command is being executed |
| rd_valid | output | 1 | One-cycle strobe for a finished read bit |
| rd_data | output | 1 | Sampled read bit |

## Verification
The completion strobe of a read bit and the acceptance of the next command can fall in the same cycle. When the sequencer has the next command waiting, `cmd_ready` rises in the same cycle that `rd_valid` is pulsing. The bench provokes this by issuing commands back to back, with no idle cycle after each read. It then checks that `rd_valid` and `rd_data` in that cycle reflect the finished read, and that the next command's waveform and length are unaffected. A second overlap also gets its own case: a `cmd_valid` that arrives mid-command, which must not disturb the running bit.

// File: rtl/mixbus_pkg.sv
// Shared command codes for the mixed-bus bit modulator.
// Assumes a 3-bit command field; codes 6 and 7 are unused.
package mixbus_pkg;
    typedef enum logic [2:0] {
        OP_OPEN   = 3'd0,
        OP_REOPEN = 3'd1,
        OP_CLOSE  = 3'd2,
        OP_WRITE  = 3'd3,
        OP_READ   = 3'd4,
        OP_ACK    = 3'd5
    } op_e;
endpackage

// File: rtl/mixbus_qtimer.sv
// Quarter-phase timer: runs one command as four quarters of equal length.
// The quarter length is QTR_TICKS, or QTR_TICKS*LEGACY_DIV in legacy mode.
// Assumes `go` is only raised when the timer is idle.
module mixbus_qtimer #(
    parameter int QTR_TICKS  = 2,
    parameter int LEGACY_DIV = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       legacy,
    output logic       run,
    output logic [1:0] qtr,
    output logic       qtr_last,
    output logic       cmd_end
);
    localparam int LEG_TICKS = QTR_TICKS * LEGACY_DIV;
    localparam int CW        = $clog2(LEG_TICKS + 1);

    logic [CW-1:0] cnt;
    logic          leg_q;
    logic [CW-1:0] qlen_m1;

    // Pick the last tick index of a quarter for the latched mode.
    always_comb begin
        qlen_m1 = leg_q ? CW'(LEG_TICKS - 1) : CW'(QTR_TICKS - 1);
    end

    assign qtr_last = run && (cnt == qlen_m1);
    assign cmd_end  = qtr_last && (qtr == 2'd3);

    // Step the tick counter and the quarter index while a command runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            qtr   <= 2'd0;
            cnt   <= '0;
            leg_q <= 1'b0;
        end else if (go && !run) begin
            run   <= 1'b1;
            qtr   <= 2'd0;
            cnt   <= '0;
            leg_q <= legacy;
        end else if (run) begin
            if (cnt == qlen_m1) begin
                cnt <= '0;
                if (qtr == 2'd3) run <= 1'b0;
                else             qtr <= qtr + 2'd1;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // R2/R3: the tick counter never passes the quarter length.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= qlen_m1));
    // R3: the latched mode stays fixed for the whole command.
    a_r3_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(go && !run)) |-> $stable(leg_q));
endmodule

// File: rtl/mixbus_wavegen.sv
// Pin pattern table: gives the SCL/SDA pull-down enables for one quarter of a
// command. Purely combinational; `rep` picks the repeated-Start form of an open.
module mixbus_wavegen
    import mixbus_pkg::*;
(
    input  op_e        op,
    input  logic       dbit,
    input  logic       rep,
    input  logic [1:0] qtr,
    output logic       scl_pd,
    output logic       sda_pd
);
    // Map command and quarter to the two enables.
    always_comb begin
        scl_pd = (qtr == 2'd0) || (qtr == 2'd3);
        sda_pd = 1'b0;
        unique case (op)
            OP_OPEN, OP_REOPEN: begin
                scl_pd = (qtr == 2'd3) || (rep && qtr == 2'd0);
                sda_pd = qtr[1];
            end
            OP_CLOSE: begin
                scl_pd = (qtr == 2'd0);
                sda_pd = !qtr[1];
            end
            OP_WRITE, OP_ACK: sda_pd = !dbit;
            default:          sda_pd = 1'b0;
        endcase
    end
endmodule

// File: rtl/mixbus_bitmod.sv
// Mixed I3C/I2C bit modulator top: accepts one bus command per handshake,
// drives open-drain enables quarter by quarter, samples read bits, and
// chooses plain or repeated Start from whether the bus is still held.
// Assumes sda_in is already synchronised to clk.
module mixbus_bitmod
    import mixbus_pkg::*;
#(
    parameter int QTR_TICKS  = 2,
    parameter int LEGACY_DIV = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [2:0] cmd_op,
    input  logic       cmd_bit,
    input  logic       cmd_legacy,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       rd_valid,
    output logic       rd_data
);
    logic       run, qtr_last, cmd_end, accept;
    logic [1:0] qtr;
    op_e        op_q, wg_op;
    logic       bit_q, rep_q, held, samp;
    logic       wg_bit, wg_rep, wg_scl, wg_sda;
    logic [1:0] wg_qtr;

    assign cmd_ready = !run;
    assign busy      = run;
    assign accept    = cmd_valid && !run;

    mixbus_qtimer #(.QTR_TICKS(QTR_TICKS), .LEGACY_DIV(LEGACY_DIV)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(accept), .legacy(cmd_legacy),
        .run(run), .qtr(qtr), .qtr_last(qtr_last), .cmd_end(cmd_end)
    );

    // Feed the table with the new command at acceptance, else the next quarter.
    always_comb begin
        if (run) begin
            wg_op = op_q; wg_bit = bit_q; wg_rep = rep_q; wg_qtr = qtr + 2'd1;
        end else begin
            wg_op = op_e'(cmd_op); wg_bit = cmd_bit; wg_rep = held; wg_qtr = 2'd0;
        end
    end

    mixbus_wavegen u_wave (
        .op(wg_op), .dbit(wg_bit), .rep(wg_rep), .qtr(wg_qtr),
        .scl_pd(wg_scl), .sda_pd(wg_sda)
    );

    // Latch the command and load the pin enables at each quarter boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_CLOSE;
            bit_q  <= 1'b1;
            rep_q  <= 1'b0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
        end else if (accept) begin
            op_q   <= op_e'(cmd_op);
            bit_q  <= cmd_bit;
            rep_q  <= held;
            scl_oe <= wg_scl;
            sda_oe <= wg_sda;
        end else if (qtr_last && !cmd_end) begin
            scl_oe <= wg_scl;
            sda_oe <= wg_sda;
        end
    end

    // Track bus ownership: any finished command but a Stop leaves it held.
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= 1'b0;
        else if (cmd_end) held <= (op_q != OP_CLOSE);
    end

    // Sample SDA at the end of quarter 1 and strobe the result after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp     <= 1'b1;
            rd_valid <= 1'b0;
            rd_data  <= 1'b0;
        end else begin
            if (qtr_last && qtr == 2'd1) samp <= sda_in;
            rd_valid <= cmd_end && (op_q == OP_READ);
            if (cmd_end && op_q == OP_READ) rd_data <= samp;
        end
    end

    // R11: acceptance is followed by a not-ready cycle.
    a_r11_accept_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
    // R9: SDA is never pulled during a read bit.
    a_r9_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (run && op_q == OP_READ) |-> !sda_oe);
    // R9: the read strobe lasts one cycle.
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R7: a finished Stop leaves both lines released and the bus free.
    a_r7_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end && op_q == OP_CLOSE) |=> (!scl_oe && !sda_oe && !held));
    // R10: ACK pulls SDA, NACK releases it, for the whole bit.
    a_r10_ack_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (run && op_q == OP_ACK) |-> (sda_oe == !bit_q));
    // R5/R8: a plain Start pulls SCL only in its last quarter.
    a_r8_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (op_q == OP_OPEN || op_q == OP_REOPEN) && !rep_q && qtr != 2'd3)
        |-> !scl_oe);
endmodule

// File: tb/mixbus_bitmod_tb.sv
module mixbus_bitmod_tb;
    localparam int QT = 2;
    localparam int LD = 3;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, cmd_bit = 0, cmd_legacy = 0, tgt_low = 0;
    logic [2:0] cmd_op = 0;
    logic cmd_ready, scl_oe, sda_oe, busy, rd_valid, rd_data, sda_in;
    int total = 0, fails = 0;

    always #5 clk = ~clk;
    assign sda_in = !(sda_oe || tgt_low);

    mixbus_bitmod #(.QTR_TICKS(QT), .LEGACY_DIV(LD)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_bit(cmd_bit), .cmd_legacy(cmd_legacy),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected {scl_oe, sda_oe} per quarter, from R4..R10.
    function automatic logic [1:0] exp_oe(input int op, input bit b,
                                          input bit rep, input int q);
        case (op)
            0, 1: begin
                if (rep) return (q == 0) ? 2'b10 : (q == 1) ? 2'b00 : (q == 2) ? 2'b01 : 2'b11;
                else     return (q < 2) ? 2'b00 : (q == 2) ? 2'b01 : 2'b11;
            end
            2: return (q == 0) ? 2'b11 : (q == 1) ? 2'b01 : 2'b00;
            4: return {(q == 0 || q == 3), 1'b0};
            default: return {(q == 0 || q == 3), !b};
        endcase
    endfunction

    // Issue one command at a negedge and judge its waveform, length and read.
    task automatic do_cmd(input int op, input bit b, input bit leg, input bit rep,
                          input bit tlow, input string req, input bit poke);
        int n = 4 * QT * (leg ? LD : 1);
        int qlen = QT * (leg ? LD : 1);
        int bad = 0, len = 0;
        logic [1:0] e, first_bad_a = 0, first_bad_e = 0;
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); cmd_bit = b; cmd_legacy = leg; tgt_low = tlow;
        @(negedge clk);
        cmd_valid = 0;
        for (int k = 0; k < n; k++) begin
            e = exp_oe(op, b, rep, k / qlen);
            if (busy) len++;
            if ({scl_oe, sda_oe} !== e) begin
                if (bad == 0) begin first_bad_a = {scl_oe, sda_oe}; first_bad_e = e; end
                bad++;
            end
            if (poke && k == 1) begin cmd_valid = 1; cmd_op = 3'd2; cmd_legacy = !leg; end
            if (poke && k == n - 2) cmd_valid = 0;
            @(negedge clk);
        end
        check(bad == 0, req, $sformatf("waveform op=%0d leg=%0d", op, leg),
              int'(first_bad_a), int'(first_bad_e));
        check(len == n && !busy, leg ? "R3" : "R2", $sformatf("busy length op=%0d", op),
              len + (busy ? 1000 : 0), n);
        if (op == 4)
            check(rd_valid === 1'b1 && rd_data === !tlow, "R9", "read strobe/data",
                  int'({rd_valid, rd_data}), int'({1'b1, !tlow}));
        else
            check(rd_valid === 1'b0, "R9", "no strobe for non-read", int'(rd_valid), 0);
        tgt_low = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(!scl_oe && !sda_oe, "R1", "lines released", int'({scl_oe, sda_oe}), 0);
        check(cmd_ready && !busy && !rd_valid, "R1", "idle handshake",
              int'({cmd_ready, busy, rd_valid}), 4);
        // R1/R5: first open is plain even with the repeated-Start code
        do_cmd(1, 0, 0, 0, 0, "R5", 0);
        // R4/R9/R10: sweep bit commands over value, mode and line level
        for (int op = 3; op <= 5; op++)
            for (int lg = 0; lg < 2; lg++)
                for (int b = 0; b < 2; b++)
                    do_cmd(op, b[0], lg[0], 0, (op == 4) ? !b[0] : 1'b0,
                           op == 3 ? "R4" : op == 4 ? "R9" : "R10", 0);
        // R6: opens on a held bus give repeated Start, both codes, both modes
        do_cmd(0, 0, 0, 1, 0, "R6", 0);
        do_cmd(1, 0, 1, 1, 0, "R6", 0);
        // R11: valid raised mid-bit is ignored
        do_cmd(3, 1, 0, 0, 0, "R11", 1);
        do_cmd(3, 0, 1, 0, 0, "R11", 1);
        // R7 then R8: Stop followed by either open code gives plain Start
        do_cmd(2, 0, 0, 0, 0, "R7", 0);
        do_cmd(1, 0, 0, 0, 0, "R8", 0);
        do_cmd(4, 0, 1, 0, 1, "R9", 0);
        do_cmd(2, 0, 1, 0, 0, "R7", 0);
        do_cmd(0, 0, 1, 0, 0, "R8", 0);
        do_cmd(2, 0, 0, 0, 0, "R7", 0);
        check(!scl_oe && !sda_oe && cmd_ready, "R7", "bus free after Stop",
              int'({scl_oe, sda_oe, cmd_ready}), 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule